// File: doc/BRIEF.md
# Cascaded event interrupt aggregator

This block gathers single-cycle event pulses from up to three times `WORD_W` sources into three pending words. It drives three level interrupt lines from them. Each event carries a number. The top two bits of that number pick the pending word, and the low bits pick the bit inside it. Each of the three interrupt lines has its own set of three mask words. A line is high while any pending bit is also enabled in its mask.

Pending words 1 and 2 are summarised into word 0. Each has a cascade bit there: bit `WORD_W-2` for word 1 and bit `WORD_W-1` for word 2. The bit is set when an event lands in that word and is dropped when the word is emptied.

Software reaches the block through a plain register bus. Every storage word is readable, and writes follow a different rule per word:
- pending word 0 is write-one-to-clear, with its cascade bits protected;
- pending word 1 is read-only;
- pending word 2 is write-one-to-clear and drops its cascade bit when it becomes empty.

A separate clear strobe removes one event by number.

Top module: `evt_irq_fold`

## Requirements
- R1: After reset all pending words and mask words read zero, and `irq_a`, `irq_b` and `irq_c` are low.
- R2: An event strobe sets the pending bit chosen by `evt_num`. Bits [6:5] give the word and bits [4:0] give the bit. Event numbers with bits [6:5] = 3 (96 to 127) change nothing.
- R3: An event in word 1 also sets word 0 bit 30. An event in word 2 also sets word 0 bit 31.
- R4: A bus write to address 0 (pending word 0) clears every bit written as one, except bits 31 and 30, which keep their value.
- R5: A bus write to address 1 (pending word 1) has no effect.
- R6: A bus write to address 2 (pending word 2) clears every bit written as one. If word 2 is then zero, word 0 bit 31 is cleared.
- R7: A clear strobe clears the one bit chosen by `clr_num`, using the same encoding as R2. If that leaves word 1 or word 2 empty, its cascade bit in word 0 is cleared. A clear strobe aimed at word 0 bit 30 or 31 has no effect.
- R8: Mask words sit at address 3 + 3*s + w, where s is 0 for line A, 1 for line B and 2 for line C, and w is the pending word. They read back what was written. A line is high exactly when some pending word ANDed with that line's mask for the same word is nonzero.
- R9: Interrupt lines are registered. They take their new value one clock after the pending or mask register changes, which is two edges after the strobe or write.
- R10: When an event set coincides in one cycle with a clear of the same bit, the set wins. The clear may come from the strobe or from a bus write, and the set also wins for the cascade bit.
- R11: Addresses 12 to 15 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Event strobe, one cycle per event |
| evt_num | input | NUM_W (7) | Event number: word in top two bits, bit below |
| clr_valid | input | 1 | Single-event clear strobe |
| clr_num | input | NUM_W (7) | Event number to clear |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | WORD_W (32) | Register write data |
| reg_rdata | output | WORD_W (32) | Addressed register, combinational |
| irq_a | output | 1 | Interrupt line A |
| irq_b | output | 1 | Interrupt line B |
| irq_c | output | 1 | Interrupt line C |

## Verification
The bench builds the block at its default `WORD_W` of 32, which makes the whole event number space of 128 codes small enough to sweep.

Every code is raised and then cleared by strobe. This covers each bit of all three words, both cascade positions and the unused fourth word. All sixteen addresses are compared against a model after each step.

Directed steps then cover several cases:
- the protected cascade bits under bus writes;
- the read-only word;
- word 2 emptying partly and then fully;
- set-versus-clear collisions;
- the one-cycle output lag after a mask change.

// File: rtl/evt_irq_fold.sv
module evt_irq_fold #(
  parameter int WORD_W = 32,
  localparam int BIT_W = $clog2(WORD_W),
  localparam int NUM_W = BIT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [NUM_W-1:0]  evt_num,
  input  logic              clr_valid,
  input  logic [NUM_W-1:0]  clr_num,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq_a,
  output logic              irq_b,
  output logic              irq_c
);
  localparam int C1 = WORD_W - 2;
  localparam int C2 = WORD_W - 1;
  localparam logic [WORD_W-1:0] CASC = {2'b11, {(WORD_W-2){1'b0}}};

  logic [WORD_W-1:0] pend [3];
  logic [WORD_W-1:0] mask [9];
  logic [WORD_W-1:0] clr_m [3];
  logic [WORD_W-1:0] kept [3];
  logic [WORD_W-1:0] nxt [3];
  logic [WORD_W*3-1:0] pend_flat;
  logic [WORD_W*9-1:0] mask_flat;
  logic [2:0] hit;
  logic drop1, drop2;

  wire [1:0]       ew = evt_num[NUM_W-1 -: 2];
  wire [BIT_W-1:0] eb = evt_num[BIT_W-1:0];
  wire [1:0]       cw = clr_num[NUM_W-1 -: 2];
  wire [BIT_W-1:0] cb = clr_num[BIT_W-1:0];

  always_comb begin
    for (int w = 0; w < 3; w++) begin
      clr_m[w] = '0;
      if (clr_valid && cw == 2'(w)) clr_m[w][cb] = 1'b1;
    end
    clr_m[0] = clr_m[0] & ~CASC;
    if (reg_we && reg_addr == 4'd0) clr_m[0] = clr_m[0] | (reg_wdata & ~CASC);
    if (reg_we && reg_addr == 4'd2) clr_m[2] = clr_m[2] | reg_wdata;
    for (int w = 0; w < 3; w++) kept[w] = pend[w] & ~clr_m[w];
    drop1 = clr_valid && cw == 2'd1 && kept[1] == '0;
    drop2 = ((clr_valid && cw == 2'd2) || (reg_we && reg_addr == 4'd2)) && kept[2] == '0;
    if (drop1) kept[0][C1] = 1'b0;
    if (drop2) kept[0][C2] = 1'b0;
    for (int w = 0; w < 3; w++) begin
      nxt[w] = kept[w];
      if (evt_valid && ew == 2'(w)) nxt[w][eb] = 1'b1;
    end
    if (evt_valid && ew == 2'd1) nxt[0][C1] = 1'b1;
    if (evt_valid && ew == 2'd2) nxt[0][C2] = 1'b1;
  end

  always_comb begin
    for (int s = 0; s < 3; s++)
      hit[s] = |((pend[0] & mask[3*s]) | (pend[1] & mask[3*s+1]) | (pend[2] & mask[3*s+2]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < 3; w++) pend[w] <= '0;
      for (int m = 0; m < 9; m++) mask[m] <= '0;
      {irq_c, irq_b, irq_a} <= 3'b000;
    end else begin
      for (int w = 0; w < 3; w++) pend[w] <= nxt[w];
      for (int m = 0; m < 9; m++)
        if (reg_we && reg_addr == 4'(m + 3)) mask[m] <= reg_wdata;
      {irq_c, irq_b, irq_a} <= hit;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int w = 0; w < 3; w++) if (reg_addr == 4'(w)) reg_rdata = pend[w];
    for (int m = 0; m < 9; m++) if (reg_addr == 4'(m + 3)) reg_rdata = mask[m];
  end

  always_comb begin
    for (int w = 0; w < 3; w++) pend_flat[w*WORD_W +: WORD_W] = pend[w];
    for (int m = 0; m < 9; m++) mask_flat[m*WORD_W +: WORD_W] = mask[m];
  end
endmodule

// File: rtl/evt_irq_fold_chk.sv
module evt_irq_fold_chk #(
  parameter int WORD_W = 32,
  localparam int BIT_W = $clog2(WORD_W),
  localparam int NUM_W = BIT_W + 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                evt_valid,
  input logic [NUM_W-1:0]    evt_num,
  input logic                clr_valid,
  input logic                reg_we,
  input logic [3:0]          reg_addr,
  input logic [WORD_W*3-1:0] pend_flat,
  input logic [WORD_W*9-1:0] mask_flat,
  input logic                irq_a
);
  wire [WORD_W-1:0] p0 = pend_flat[0 +: WORD_W];
  wire [WORD_W-1:0] p1 = pend_flat[WORD_W +: WORD_W];
  wire [WORD_W-1:0] p2 = pend_flat[2*WORD_W +: WORD_W];
  wire a_zero = ~|mask_flat[3*WORD_W-1:0];

  assert_casc_word2_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|p2) |-> p0[WORD_W-1]);

  assert_casc_word1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|p1) |-> p0[WORD_W-2]);

  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_num[NUM_W-1 -: 2] != 2'd3) |=>
      pend_flat[{$past(evt_num[NUM_W-1 -: 2]), $past(evt_num[BIT_W-1:0])}]);

  assert_word1_ro_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 4'd1 && !evt_valid && !clr_valid) |=> $stable(p1));

  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(a_zero) |-> !irq_a);
endmodule

bind evt_irq_fold evt_irq_fold_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_num(evt_num),
  .clr_valid(clr_valid), .reg_we(reg_we), .reg_addr(reg_addr),
  .pend_flat(pend_flat), .mask_flat(mask_flat), .irq_a(irq_a)
);

// File: tb/sim_evt_irq_fold.sv
module sim_evt_irq_fold;
  localparam int CLK_P = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic evt_valid = 1'b0, clr_valid = 1'b0, reg_we = 1'b0;
  logic [6:0] evt_num = '0, clr_num = '0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq_a, irq_b, irq_c;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] mp [3];
  logic [31:0] mm [9];

  always #(CLK_P/2) clk = ~clk;

  evt_irq_fold u0 (.clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_num(evt_num),
    .clr_valid(clr_valid), .clr_num(clr_num), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_a(irq_a), .irq_b(irq_b), .irq_c(irq_c));

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_reg(input int a);
    if (a < 3) return mp[a];
    if (a < 12) return mm[a-3];
    return '0;
  endfunction

  function automatic logic model_irq(input int s);
    return |((mp[0] & mm[3*s]) | (mp[1] & mm[3*s+1]) | (mp[2] & mm[3*s+2]));
  endfunction

  task automatic check_all(input string tag);
    @(negedge clk);
    for (int a = 0; a < 16; a++) begin
      reg_addr = 4'(a);
      #1;
      chk(tag, $sformatf("reg %0d", a), reg_rdata, model_reg(a));
    end
    chk(tag, "irq_a", {31'b0, irq_a}, {31'b0, model_irq(0)});
    chk(tag, "irq_b", {31'b0, irq_b}, {31'b0, model_irq(1)});
    chk(tag, "irq_c", {31'b0, irq_c}, {31'b0, model_irq(2)});
  endtask

  task automatic model_apply(input bit ev_en, input logic [6:0] ev, input bit cl_en,
                             input logic [6:0] cl, input bit we, input int a, input logic [31:0] d);
    logic [31:0] c [3];
    logic [31:0] k [3];
    bit d1, d2;
    for (int w = 0; w < 3; w++) c[w] = '0;
    if (cl_en && cl[6:5] != 2'd3 && !(cl[6:5] == 2'd0 && cl[4:0] >= 5'd30)) c[cl[6:5]][cl[4:0]] = 1'b1;
    if (we && a == 0) c[0] = c[0] | (d & 32'h3FFF_FFFF);
    if (we && a == 2) c[2] = c[2] | d;
    for (int w = 0; w < 3; w++) k[w] = mp[w] & ~c[w];
    d1 = cl_en && cl[6:5] == 2'd1 && k[1] == 0;
    d2 = ((cl_en && cl[6:5] == 2'd2) || (we && a == 2)) && k[2] == 0;
    if (d1) k[0][30] = 1'b0;
    if (d2) k[0][31] = 1'b0;
    if (ev_en && ev[6:5] != 2'd3) begin
      k[ev[6:5]][ev[4:0]] = 1'b1;
      if (ev[6:5] == 2'd1) k[0][30] = 1'b1;
      if (ev[6:5] == 2'd2) k[0][31] = 1'b1;
    end
    for (int w = 0; w < 3; w++) mp[w] = k[w];
    if (we && a >= 3 && a < 12) mm[a-3] = d;
  endtask

  task automatic drive(input bit ev_en, input logic [6:0] ev, input bit cl_en,
                       input logic [6:0] cl, input bit we, input int a, input logic [31:0] d);
    @(negedge clk);
    evt_valid = ev_en; evt_num = ev; clr_valid = cl_en; clr_num = cl;
    reg_we = we; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    evt_valid = 1'b0; clr_valid = 1'b0; reg_we = 1'b0;
    model_apply(ev_en, ev, cl_en, cl, we, a, d);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    drive(1'b0, '0, 1'b0, '0, 1'b1, a, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 3; w++) mp[w] = '0;
    for (int m = 0; m < 9; m++) mm[m] = '0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    check_all("R1");

    // R8: mask programming and readback
    for (int w = 0; w < 3; w++) wr(3 + w, 32'hFFFF_FFFF);
    wr(7, 32'hFFFF_FFFF);
    wr(9, 32'h5555_5555);
    check_all("R8");

    // R2 / R3 / R7: sweep every event number, set then clear
    for (int e = 0; e < 128; e++) begin
      drive(1'b1, 7'(e), 1'b0, '0, 1'b0, 15, '0);
      check_all(e < 96 ? ((e >= 32) ? "R3" : "R2") : "R2");
      drive(1'b0, '0, 1'b1, 7'(e), 1'b0, 15, '0);
      check_all("R7");
    end

    // R4: write-one-to-clear on word 0 keeps cascade bits
    drive(1'b1, 7'd0, 1'b0, '0, 1'b0, 15, '0);
    drive(1'b1, 7'd5, 1'b0, '0, 1'b0, 15, '0);
    drive(1'b1, 7'd40, 1'b0, '0, 1'b0, 15, '0);
    drive(1'b1, 7'd70, 1'b0, '0, 1'b0, 15, '0);
    drive(1'b1, 7'd75, 1'b0, '0, 1'b0, 15, '0);
    wr(0, 32'hFFFF_FFFF);
    check_all("R4");
    chk("R4", "word0 cascade", mp[0], 32'hC000_0000);

    // R5: word 1 ignores writes
    wr(1, 32'hFFFF_FFFF);
    check_all("R5");

    // R6: partial then full clear of word 2
    wr(2, 32'h0000_0040);
    check_all("R6");
    wr(2, 32'h0000_0800);
    check_all("R6");

    // R7: strobe on word-0 cascade positions is ignored; emptying word 1 drops bit 30
    drive(1'b0, '0, 1'b1, 7'd30, 1'b0, 15, '0);
    check_all("R7");
    drive(1'b0, '0, 1'b1, 7'd40, 1'b0, 15, '0);
    check_all("R7");

    // R10: same-bit set and clear collide
    drive(1'b1, 7'd66, 1'b1, 7'd66, 1'b0, 15, '0);
    check_all("R10");
    drive(1'b1, 7'd90, 1'b0, '0, 1'b1, 2, 32'hFFFF_FFFF);
    check_all("R10");

    // R11: unused addresses
    for (int a = 12; a < 16; a++) wr(a, 32'hFFFF_FFFF);
    check_all("R11");

    // R9: output lags the mask change by one clock
    wr(3, '0); wr(4, '0); wr(5, '0); wr(7, '0); wr(9, '0);
    check_all("R9");
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'd11; reg_wdata = 32'h0400_0000;
    @(negedge clk);
    reg_we = 1'b0;
    model_apply(1'b0, '0, 1'b0, '0, 1'b1, 11, 32'h0400_0000);
    chk("R9", "irq_c before lag", {31'b0, irq_c}, 32'd0);
    @(negedge clk);
    chk("R9", "irq_c after lag", {31'b0, irq_c}, 32'd1);
    check_all("R9");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule